// File: doc/BRIEF.md
# Run-to-Completion Task Dispatcher

This block schedules work for a small co-processor that runs one routine at a time. It holds eight request slots, each with its own pending flag. A slot is raised either by a software request line or by a pulse from one of several peripheral event sources, for example a converter end-of-conversion, a PWM event or a timer tick. Each slot chooses its event source with a select field and can mask hardware events with an enable bit.

While the co-processor is free, the dispatcher takes the pending slot with the lowest index. It clears that slot's flag and pulses a start strobe with the slot number. It then waits for the co-processor's done signal. A started routine always runs to completion, even if a more urgent request arrives in the meantime. When done arrives, a completion interrupt for that slot goes to the host, and in the same cycle the next pending slot, if any, is launched without host involvement.

Top module: `task_dispatch`

## Requirements
- R1: A software request on `sw_set[i]` sets pending flag i, visible on `pend_o[i]` after the clock edge that samples it, regardless of `hw_en`.
- R2: Slot i takes hardware events from source `hw_trig[src_sel[2i+1:2i]]` only. A pulse on that source sets pending flag i only while `hw_en[i]` is 1. A pulse on any other source, or with `hw_en[i]` at 0, leaves `pend_o[i]` unchanged.
- R3: Priority is fixed. When several slots are eligible, slot 0 (bit 0) wins over slot 1, and so on up to slot 7, which is lowest.
- R4: A launch shows as `start_o` high for exactly one cycle, with the chosen slot on `start_idx`. That slot's pending bit reads 0 in the same cycle, and the launch happens one edge after the pending flag first becomes visible while idle.
- R5: `running_o` is high from a launch until the done that ends it. While it is high and `done_i` is low, no new launch occurs, whatever requests arrive.
- R6: `done_i` high while running produces, after that edge, a one-cycle one-hot pulse on `irq_o` at the bit of the finished slot. `done_i` while not running is ignored and produces no interrupt.
- R7: On the edge that accepts done, the highest-priority remaining pending slot is launched at once. `start_o` and `irq_o` are high in the same cycle and `running_o` stays high. With nothing pending, `running_o` falls.
- R8: A request for a slot that is already pending is merged into the one flag and sets the sticky bit `ovf_o[i]`. That bit stays set until reset.
- R9: A request for the slot currently running sets its pending flag again, so the slot is launched once more after it completes.
- R10: `sw_clr[i]` clears pending flag i. A request to the same slot in the same cycle wins and leaves the flag set.
- R11: Synchronous active-high `rst` clears all pending, overflow, running, start and interrupt state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_trig | input | NSRC (4) | Peripheral event pulses, one per source |
| src_sel | input | NTASK*SELW (16) | Per-slot event source select, 2 bits per slot |
| hw_en | input | NTASK (8) | Per-slot hardware event enable |
| sw_set | input | NTASK (8) | Software request, one per slot |
| sw_clr | input | NTASK (8) | Software clear of a pending flag |
| done_i | input | 1 | Co-processor finished the current routine |
| start_o | output | 1 | One-cycle launch strobe |
| start_idx | output | IW (3) | Slot number that was launched |
| running_o | output | 1 | Co-processor is busy with a routine |
| irq_o | output | NTASK (8) | One-hot completion interrupt pulse |
| pend_o | output | NTASK (8) | Pending flags |
| ovf_o | output | NTASK (8) | Sticky merged-request flags |

## Verification
A corrupted pending vector shows on `pend_o` one edge after it forms. It also changes the next `start_idx`, which the exhaustive sweep over all 255 request patterns compares against the lowest set bit. A wrong record of the running slot does not show until its done, and then it appears as the wrong bit on `irq_o`. A stuck busy state shows as a launch that is missing one edge after done. The directed sequence checks merging, re-arming of the running slot, clearing and overflow stickiness, each on the cycle after the stimulus.

// File: rtl/td_pkg.sv
package td_pkg;
  typedef enum logic {
    DISP_IDLE = 1'b0,
    DISP_BUSY = 1'b1
  } disp_st_e;
endpackage

// File: rtl/td_trig_route.sv
module td_trig_route #(
  parameter int NTASK = 8,
  parameter int NSRC  = 4,
  parameter int SELW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]       hw_trig,
  input  logic [NTASK*SELW-1:0] src_sel,
  input  logic [NTASK-1:0]      hw_en,
  input  logic [NTASK-1:0]      sw_set,
  output logic [NTASK-1:0]      req
);
  for (genvar t = 0; t < NTASK; t++) begin : g_slot
    logic [SELW-1:0] sel;
    logic            hit;
    assign sel = src_sel[t*SELW +: SELW];
    assign hit = (int'(sel) < NSRC) ? hw_trig[sel] : 1'b0;
    assign req[t] = sw_set[t] | (hw_en[t] & hit);
  end
endmodule

// File: rtl/td_pick.sv
module td_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign any = |vec;

  always_comb begin
    if (any) begin
      // R3
      pick_hit_chk: assert (vec[idx]);
      // R3
      pick_lowest_chk: assert ((vec & ((N'(1) << idx) - N'(1))) == '0);
    end
  end
endmodule

// File: rtl/td_pend_bank.sv
module td_pend_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic [N-1:0] take,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] ovf_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      ovf_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~take & ~clr) | req;
      ovf_q  <= ovf_q | (req & pend_q & ~take & ~clr);
    end
  end

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

  // R1
  pend_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |=> ((pend_q & $past(req)) == $past(req)));
endmodule

// File: rtl/task_dispatch.sv
module task_dispatch #(
  parameter int NTASK = 8,
  parameter int NSRC  = 4,
  parameter int SELW  = (NSRC > 1) ? $clog2(NSRC) : 1,
  parameter int IW    = (NTASK > 1) ? $clog2(NTASK) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSRC-1:0]       hw_trig,
  input  logic [NTASK*SELW-1:0] src_sel,
  input  logic [NTASK-1:0]      hw_en,
  input  logic [NTASK-1:0]      sw_set,
  input  logic [NTASK-1:0]      sw_clr,
  input  logic                  done_i,
  output logic                  start_o,
  output logic [IW-1:0]         start_idx,
  output logic                  running_o,
  output logic [NTASK-1:0]      irq_o,
  output logic [NTASK-1:0]      pend_o,
  output logic [NTASK-1:0]      ovf_o
);
  import td_pkg::*;

  logic [NTASK-1:0] req, take, eligible, pend_q, ovf_q, irq_q;
  logic             any, idle_now, start_q, busy;
  logic [IW-1:0]    pick_idx, cur_q, sidx_q;
  disp_st_e         st_q;

  td_trig_route #(.NTASK(NTASK), .NSRC(NSRC), .SELW(SELW)) u_route (
    .hw_trig(hw_trig), .src_sel(src_sel), .hw_en(hw_en),
    .sw_set(sw_set), .req(req)
  );

  td_pend_bank #(.N(NTASK)) u_bank (
    .clk(clk), .rst(rst), .req(req), .take(take), .clr(sw_clr),
    .pend_q(pend_q), .ovf_q(ovf_q)
  );

  assign eligible = pend_q & ~sw_clr;

  td_pick #(.N(NTASK), .IW(IW)) u_pick (
    .vec(eligible), .any(any), .idx(pick_idx)
  );

  assign busy     = (st_q == DISP_BUSY);
  assign idle_now = !busy || done_i;
  assign take     = (idle_now && any) ? (NTASK'(1) << pick_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= DISP_IDLE;
      cur_q   <= '0;
      sidx_q  <= '0;
      start_q <= 1'b0;
      irq_q   <= '0;
    end else begin
      start_q <= idle_now && any;
      irq_q   <= (busy && done_i) ? (NTASK'(1) << cur_q) : '0;
      if (idle_now) begin
        if (any) begin
          st_q   <= DISP_BUSY;
          cur_q  <= pick_idx;
          sidx_q <= pick_idx;
        end else begin
          st_q <= DISP_IDLE;
        end
      end
    end
  end

  assign start_o   = start_q;
  assign start_idx = sidx_q;
  assign running_o = busy;
  assign irq_o     = irq_q;
  assign pend_o    = pend_q;
  assign ovf_o     = ovf_q;

  // R5
  busy_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done_i) |=> !start_q);

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start_q |-> busy);

  // R6
  irq_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_q));

  // R6
  idle_done_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (irq_q == '0));

  // R7
  chain_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && done_i && (eligible != '0)) |=> (start_q && busy && (irq_q != '0)));
endmodule

// File: tb/task_dispatch_bench.sv
module task_dispatch_bench;
  localparam int CLK_P = 10;
  localparam int NTASK = 8;
  localparam int NSRC  = 4;
  localparam int SELW  = 2;
  localparam int IW    = 3;

  logic                  clk = 1'b0;
  logic                  rst;
  logic [NSRC-1:0]       hw_trig;
  logic [NTASK*SELW-1:0] src_sel;
  logic [NTASK-1:0]      hw_en, sw_set, sw_clr;
  logic                  done_i;
  logic                  start_o, running_o;
  logic [IW-1:0]         start_idx;
  logic [NTASK-1:0]      irq_o, pend_o, ovf_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  task_dispatch u_task_dispatch (
    .clk(clk), .rst(rst), .hw_trig(hw_trig), .src_sel(src_sel),
    .hw_en(hw_en), .sw_set(sw_set), .sw_clr(sw_clr), .done_i(done_i),
    .start_o(start_o), .start_idx(start_idx), .running_o(running_o),
    .irq_o(irq_o), .pend_o(pend_o), .ovf_o(ovf_o)
  );

  initial forever #(CLK_P / 2) clk = ~clk;

  task automatic chk(input string r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; hw_trig = '0; src_sel = '0; hw_en = '0;
    sw_set = '0; sw_clr = '0; done_i = 1'b0;
    tick(); tick();
    rst = 1'b0;
  endtask

  function automatic int lowest(input logic [7:0] m);
    for (int i = 7; i >= 0; i--) if (m[i]) lowest = i;
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rem;
    int cur, l;

    // R11 reset state
    do_reset();
    chk("R11", "pend", pend_o, 0);
    chk("R11", "ovf", ovf_o, 0);
    chk("R11", "running", running_o, 0);
    chk("R11", "start", start_o, 0);
    chk("R11", "irq", irq_o, 0);

    // R3 R4 R6 R7 exhaustive sweep over all request patterns
    for (int m = 1; m < 256; m++) begin
      do_reset();
      sw_set = 8'(m);
      tick();
      sw_set = '0;
      chk("R1", "pend after sw_set", pend_o, m);
      chk("R4", "no start before dispatch", start_o, 0);
      tick();
      l = lowest(8'(m));
      rem = 8'(m) & ~(8'd1 << l);
      chk("R4", "start", start_o, 1);
      chk("R3", "start_idx", start_idx, l);
      chk("R4", "pend cleared on start", pend_o, rem);
      chk("R5", "running", running_o, 1);
      cur = l;
      forever begin
        tick();
        chk("R4", "start one cycle", start_o, 0);
        chk("R6", "no irq before done", irq_o, 0);
        done_i = 1'b1;
        tick();
        done_i = 1'b0;
        chk("R6", "irq", irq_o, 32'd1 << cur);
        if (rem != 0) begin
          l = lowest(rem);
          rem = rem & ~(8'd1 << l);
          chk("R7", "chained start", start_o, 1);
          chk("R3", "chained idx", start_idx, l);
          chk("R7", "running kept", running_o, 1);
          cur = l;
        end else begin
          chk("R7", "no start when empty", start_o, 0);
          chk("R7", "running falls", running_o, 0);
          break;
        end
      end
    end

    // R2 source routing and enable mask
    for (int t = 0; t < NTASK; t++) begin
      for (int s = 0; s < NSRC; s++) begin
        do_reset();
        src_sel = {NTASK{2'((s + 1) % NSRC)}};
        src_sel[t*SELW +: SELW] = 2'(s);
        hw_en = 8'd1 << t;
        hw_trig = 4'd1 << ((s + 1) % NSRC);
        tick();
        hw_trig = '0;
        chk("R2", "other source ignored", pend_o, 0);
        hw_en = '0;
        hw_trig = 4'd1 << s;
        tick();
        hw_trig = '0;
        chk("R2", "masked trigger ignored", pend_o, 0);
        hw_en = 8'd1 << t;
        hw_trig = 4'd1 << s;
        tick();
        hw_trig = '0;
        chk("R2", "routed trigger", pend_o, 32'd1 << t);
        tick();
        chk("R2", "routed start idx", start_idx, t);
      end
    end

    // R5 R8 R9 R10 directed sequence
    do_reset();
    hw_en = '0;
    sw_set = 8'h01;
    tick();
    sw_set = 8'h10;
    tick();
    chk("R5", "slot0 running", running_o, 1);
    chk("R5", "slot0 idx", start_idx, 0);
    sw_set = '0;
    chk("R1", "pend 4", pend_o, 8'h10);
    tick(); tick();
    chk("R5", "no preemption", start_o, 0);
    chk("R5", "pend held", pend_o, 8'h10);
    chk("R8", "ovf still clear", ovf_o, 0);
    sw_set = 8'h10;
    tick();
    chk("R8", "merged pend", pend_o, 8'h10);
    chk("R8", "ovf set", ovf_o, 8'h10);
    sw_set = 8'h01;
    tick();
    chk("R9", "running slot re-armed", pend_o, 8'h11);
    chk("R8", "no ovf for running slot", ovf_o, 8'h10);
    sw_set = '0;
    sw_clr = 8'h10;
    tick();
    chk("R10", "clear", pend_o, 8'h01);
    sw_set = 8'h20;
    sw_clr = 8'h20;
    tick();
    sw_set = '0;
    sw_clr = '0;
    chk("R10", "set wins over clear", pend_o, 8'h21);
    done_i = 1'b1;
    tick();
    chk("R9", "irq slot0", irq_o, 8'h01);
    chk("R9", "slot0 relaunched", start_o, 1);
    chk("R9", "relaunch idx", start_idx, 0);
    chk("R8", "ovf sticky", ovf_o, 8'h10);
    tick();
    chk("R7", "next after slot0", start_idx, 5);
    chk("R6", "irq slot0 again", irq_o, 8'h01);
    tick();
    chk("R6", "irq slot5", irq_o, 8'h20);
    chk("R7", "idle after last", running_o, 0);
    tick();
    chk("R6", "done while idle ignored", irq_o, 0);
    chk("R6", "no start while idle", start_o, 0);
    done_i = 1'b0;

    // R11 reset during a run
    sw_set = 8'h06;
    tick();
    sw_set = '0;
    tick();
    chk("R3", "slot1 first", start_idx, 1);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R11", "pend cleared", pend_o, 0);
    chk("R11", "ovf cleared", ovf_o, 0);
    chk("R11", "running cleared", running_o, 0);
    chk("R11", "start cleared", start_o, 0);

    finish_run();
  end
endmodule